// File: doc/BRIEF.md
# Span Fill Unit with Carry

This block turns a word of outline bits into a filled word. It walks the bits of each incoming word from the least significant upward. While it does so it keeps one "inside" flag. Each set outline bit changes that flag, and every output bit is derived from it. The flag leaving the top bit is kept in a register and becomes the starting flag for the next word of the same row. A row that is wider than one word is therefore filled correctly across the word boundaries.

Two fill styles are offered:

- **Exclusive.** Only the pixels strictly inside a span come out set. The closing edge is dropped.
- **Inclusive.** Both edges of each span come out set.

When neither style is selected, words pass straight through. A start-of-row pulse loads the fill style and the initial flag from a three-bit configuration input. A word presented in the same cycle as that pulse already uses the newly loaded settings. Results appear one clock after the word strobe.

Top module: `span_fill_unit`

## Requirements
- R1: After reset, `out_valid`, `out_word` and `carry_out` are 0 and no fill style is selected. A word sent before any row start therefore passes through unchanged.
- R2: `out_valid` equals `in_valid` of the previous cycle. `out_word` holds the result for the word presented in that previous cycle.
- R3: Exclusive style (`cfg[2]`=1). Bits are scanned from bit 0 upward. A set input bit toggles the flag before that bit is output, and each output bit equals the updated flag. Example: with a start flag of 0, 0x0810 gives 0x07F0.
- R4: Inclusive style (`cfg[2]`=0, `cfg[1]`=1). Bits are scanned from bit 0 upward.
  - A set input bit with the flag clear sets the flag and outputs 1.
  - A set input bit with the flag set outputs 1 and then clears the flag.
  - A clear input bit outputs the flag.
  - Example: with a start flag of 0, 0x0810 gives 0x0FF0.
- R5: When `cfg[2]` and `cfg[1]` are both set, the exclusive style is used.
- R6: With neither style selected, `out_word` equals the input word and `carry_out` keeps its value.
- R7: In either fill style, the flag leaving the top bit is stored in `carry_out`. That stored flag starts the scan of the next word. Example (exclusive, start flag 0): 0x0010 then 0x0100 give 0xFFF0 then 0x00FF.
- R8: On `row_start`, the fill style is loaded from `cfg[2:1]` and `carry_out` is reloaded from `cfg[0]`. A word accepted in the same cycle uses the newly loaded style and flag.
- R9: In a cycle with `in_valid` low, `out_word` keeps its value. `carry_out` also keeps its value unless `row_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_start | input | 1 | Start-of-row pulse; loads style and initial flag |
| cfg | input | 3 | [2] exclusive style, [1] inclusive style, [0] initial flag |
| in_valid | input | 1 | Word strobe |
| in_word | input | WORD_W | Outline bits, bit 0 scanned first |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | WORD_W | Filled word |
| carry_out | output | 1 | Stored flag carried into the next word |

## Verification
The bench builds the block with its default parameters: a 16-bit word scanned as four 4-bit segments. With these values the carry has to ripple through three segment boundaries inside each word and then cross the word boundary through the register. The known spans cover every segment position. The randomized phase mixes styles and row starts with gaps in the strobe, so each segment join is exercised with both flag values in both styles.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [1:0] {
    FM_PASS = 2'd0,
    FM_INCL = 2'd1,
    FM_EXCL = 2'd2
  } fill_mode_e;

  localparam int CFG_W    = 3;
  localparam int CFG_EXCL = 2;
  localparam int CFG_INCL = 1;
  localparam int CFG_FLAG = 0;

  // Exclusive wins when both style bits are set.
  function automatic fill_mode_e decode_mode(input logic excl_bit, input logic incl_bit);
    if (excl_bit)      return FM_EXCL;
    else if (incl_bit) return FM_INCL;
    else               return FM_PASS;
  endfunction

endpackage

// File: rtl/sfu_segment.sv
module sfu_segment #(
  parameter int SEG_W = 4
) (
  input  logic             excl,
  input  logic             flag_in,
  input  logic [SEG_W-1:0] seg_in,
  output logic [SEG_W-1:0] seg_out,
  output logic             flag_out
);

  // Bit-serial scan inside one segment, lowest bit first.
  always_comb begin
    logic flag;
    flag    = flag_in;
    seg_out = '0;
    for (int i = 0; i < SEG_W; i++) begin
      if (excl) begin
        flag       = flag ^ seg_in[i];
        seg_out[i] = flag;
      end else begin
        seg_out[i] = flag | seg_in[i];
        flag       = flag ^ seg_in[i];
      end
    end
    flag_out = flag;
  end

endmodule

// File: rtl/sfu_fill_chain.sv
module sfu_fill_chain #(
  parameter int WORD_W = 16,
  parameter int SEG_W  = 4
) (
  input  sfu_pkg::fill_mode_e mode,
  input  logic                flag_in,
  input  logic [WORD_W-1:0]   word_in,
  output logic [WORD_W-1:0]   word_out,
  output logic                flag_out
);

  localparam int NSEG = WORD_W / SEG_W;

  logic [NSEG:0]       link;
  logic [WORD_W-1:0]   filled;
  logic                excl;

  assign excl    = (mode == sfu_pkg::FM_EXCL);
  assign link[0] = flag_in;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    sfu_segment #(.SEG_W(SEG_W)) u_seg (
      .excl    (excl),
      .flag_in (link[s]),
      .seg_in  (word_in[s*SEG_W +: SEG_W]),
      .seg_out (filled[s*SEG_W +: SEG_W]),
      .flag_out(link[s+1])
    );
  end

  assign word_out = (mode == sfu_pkg::FM_PASS) ? word_in : filled;
  assign flag_out = link[NSEG];

endmodule

// File: rtl/span_fill_unit.sv
module span_fill_unit #(
  parameter int WORD_W = 16,
  parameter int SEG_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      row_start,
  input  logic [sfu_pkg::CFG_W-1:0] cfg,
  input  logic                      in_valid,
  input  logic [WORD_W-1:0]         in_word,
  output logic                      out_valid,
  output logic [WORD_W-1:0]         out_word,
  output logic                      carry_out
);
  import sfu_pkg::*;

  fill_mode_e        mode_q;
  logic              flag_q;
  logic              valid_q;
  logic [WORD_W-1:0] word_q;

  // Named events for the checker.
  fill_mode_e        eff_mode;
  logic              eff_flag;
  logic              eff_excl;
  logic              eff_fill;
  logic [WORD_W-1:0] chain_word;
  logic              chain_flag;

  assign eff_mode = row_start ? decode_mode(cfg[CFG_EXCL], cfg[CFG_INCL]) : mode_q;
  assign eff_flag = row_start ? cfg[CFG_FLAG] : flag_q;
  assign eff_excl = (eff_mode == FM_EXCL);
  assign eff_fill = (eff_mode != FM_PASS);

  sfu_fill_chain #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_chain (
    .mode    (eff_mode),
    .flag_in (eff_flag),
    .word_in (in_word),
    .word_out(chain_word),
    .flag_out(chain_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= FM_PASS;
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (row_start) begin
        mode_q <= eff_mode;
        flag_q <= eff_flag;
      end
      if (in_valid) begin
        word_q <= chain_word;
        if (eff_fill) flag_q <= chain_flag;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;
  assign carry_out = flag_q;

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_start,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              eff_flag,
  input logic              eff_excl,
  input logic              eff_fill,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              carry_out
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7: every set bit flips the flag once, so carry equals start flag xor parity
  a_r7_carry_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_fill) |=> carry_out == $past(eff_flag ^ (^in_word)));
  // R3: top output bit in exclusive style is the flag leaving the word
  a_r3_top_bit_is_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_excl) |=> out_word[WORD_W-1] == carry_out);
  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !eff_fill) |=> (out_word == $past(in_word)) && (carry_out == $past(eff_flag)));
  a_r8_row_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && !in_valid) |=> carry_out == $past(eff_flag));
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));
  a_r9_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !row_start) |=> $stable(carry_out));

endmodule

bind span_fill_unit sfu_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .row_start(row_start),
  .in_valid (in_valid),
  .in_word  (in_word),
  .eff_flag (eff_flag),
  .eff_excl (eff_excl),
  .eff_fill (eff_fill),
  .out_valid(out_valid),
  .out_word (out_word),
  .carry_out(carry_out)
);

// File: tb/span_fill_unit_test.sv
module span_fill_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_start = 1'b0;
  logic [2:0]  cfg = 3'b000;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = 16'h0000;
  logic        out_valid;
  logic [15:0] out_word;
  logic        carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state
  int          m_style = 0;   // 0 pass, 1 inclusive, 2 exclusive
  bit          m_flag  = 1'b0;
  bit          m_valid = 1'b0;
  logic [15:0] m_word  = 16'h0000;

  always #10 clk = ~clk;

  span_fill_unit uut (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .cfg(cfg),
    .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word), .carry_out(carry_out)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model(input bit rs, input logic [2:0] c, input bit v, input logic [15:0] w);
    if (rs) begin
      if (c[2])      m_style = 2;
      else if (c[1]) m_style = 1;
      else           m_style = 0;
      m_flag = c[0];
    end
    m_valid = v;
    if (v) begin
      if (m_style == 0) m_word = w;
      else begin
        for (int i = 0; i < 16; i++) begin
          if (m_style == 2) begin
            if (w[i]) m_flag = !m_flag;
            m_word[i] = m_flag;
          end else begin
            if (w[i] && !m_flag)     begin m_flag = 1'b1; m_word[i] = 1'b1; end
            else if (w[i] && m_flag) begin m_word[i] = 1'b1; m_flag = 1'b0; end
            else                     m_word[i] = m_flag;
          end
        end
      end
    end
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic step(input string tag, input bit rs, input logic [2:0] c,
                      input bit v, input logic [15:0] w);
    row_start = rs; cfg = c; in_valid = v; in_word = w;
    model(rs, c, v, w);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 valid"}, {15'd0, out_valid}, {15'd0, m_valid});
    chk({tag, " word"}, out_word, m_word);
    chk({tag, " carry"}, {15'd0, carry_out}, {15'd0, m_flag});
    row_start = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {15'd0, out_valid}, 16'd0);
    chk("R1 reset word", out_word, 16'h0000);
    chk("R1 reset carry", {15'd0, carry_out}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R1 pass after reset", 0, 3'b000, 1, 16'h0810);
    chk("R1 pass value", out_word, 16'h0810);

    step("R3 excl", 1, 3'b100, 1, 16'h0810);
    chk("R3 excl span", out_word, 16'h07F0);
    step("R4 incl", 1, 3'b010, 1, 16'h0810);
    chk("R4 incl span", out_word, 16'h0FF0);
    step("R5 both", 1, 3'b110, 1, 16'h0810);
    chk("R5 excl wins", out_word, 16'h07F0);

    step("R7 excl w0", 1, 3'b100, 1, 16'h0010);
    chk("R7 excl first", out_word, 16'hFFF0);
    chk("R7 excl carry", {15'd0, carry_out}, 16'd1);
    step("R9 gap", 0, 3'b000, 0, 16'hFFFF);
    chk("R9 word held", out_word, 16'hFFF0);
    chk("R9 carry held", {15'd0, carry_out}, 16'd1);
    step("R7 excl w1", 0, 3'b000, 1, 16'h0100);
    chk("R7 excl second", out_word, 16'h00FF);

    step("R7 incl w0", 1, 3'b010, 1, 16'h0010);
    step("R7 incl w1", 0, 3'b000, 1, 16'h0100);
    chk("R7 incl second", out_word, 16'h01FF);

    step("R8 seed", 1, 3'b101, 1, 16'h0000);
    chk("R8 initial flag", out_word, 16'hFFFF);
    step("R8 reload only", 1, 3'b100, 0, 16'h0000);
    chk("R8 carry reloaded", {15'd0, carry_out}, 16'd0);
    step("R8 after reload", 0, 3'b000, 1, 16'h0000);
    chk("R8 cleared fill", out_word, 16'h0000);

    step("R6 seed", 1, 3'b001, 1, 16'h1234);
    chk("R6 pass word", out_word, 16'h1234);
    chk("R6 pass carry", {15'd0, carry_out}, 16'd1);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      w = 16'($urandom) & 16'($urandom);
      step("R7 random", ($urandom % 6) == 0, 3'($urandom), ($urandom % 4) != 0, w);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule